// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Command Front End

This block is the digital side of an eight-channel digital-to-analog converter. A host drives four slow pins: a serial clock, a serial data line, a load strobe and an update strobe. The block samples all four into a fast system clock domain and finds their edges there. While the load strobe is high, it shifts in one serial bit on every falling edge of the serial clock.

A command word holds a channel address, a range bit and a code. A falling edge of the load strobe writes the range bit and the code into the held register of the addressed channel. If the update strobe is low at that moment, the new value also goes to that channel's output register at once. If the update strobe is high, the outputs keep their values. The next falling edge of the update strobe then copies all eight held registers to the outputs together.

The outputs give each channel's code and range bit to the analog stage. The host may send extra leading bits, for example two 8-bit groups. Only the most recent command-word-length bits count.

Top module: `octal_dac_frontend`

## Requirements
- R1: A synchronous reset (rst_n low at a clk edge) clears every code and range output, every held register and the shift register to 0.
- R2: A bit is shifted in only on a falling edge of ser_clk while ser_ld is high. ser_clk edges while ser_ld is low leave the shift register unchanged.
- R3: The command word is 12 bits, sent most significant bit first. In arrival order it holds the 3-bit channel address (MSB first), then the range bit, then the 8-bit code (MSB first).
- R4: Address value n selects channel n (0 to 7). Channel n drives code_o[n*8 +: 8] and range_o[n].
- R5: On a falling edge of ser_ld with upd_n low, only the addressed channel's outputs take the new code and range. All other channels keep theirs.
- R6: On a falling edge of ser_ld with upd_n high, the held register takes the new value and no output changes.
- R7: A falling edge of upd_n copies every channel's held code and range to its outputs in the same cycle.
- R8: When more than 12 bits are shifted before ser_ld falls, only the last 12 are used.
- R9: When the ser_ld and upd_n falling edges reach the block in the same system cycle, the new word is written first, so the new value reaches the outputs along with all other held values.
- R10: Outputs change only in the cycle after a detected ser_ld or upd_n falling edge. That update lands 3 clk edges after the pin edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock pin; its falling edge samples data |
| ser_dat | input | 1 | Serial data pin |
| ser_ld | input | 1 | Load strobe: high while shifting, falling edge commits the word |
| upd_n | input | 1 | Update strobe: low means immediate update; falling edge transfers all channels |
| code_o | output | 64 | Eight 8-bit output codes, channel n at bits n*8 +: 8 |
| range_o | output | 8 | Eight range bits (0 = x1, 1 = x2), channel n at bit n |

## Verification
A wrong held register stays hidden until the next update-strobe falling edge. Then it shows as a wrong code on a channel the host never touched. For this reason the bench always follows a deferred write with a global transfer and compares all eight lanes. A shift register that slips by one bit shows up as a wrong address or a code shifted by one. It appears on the outputs three system cycles after the load edge. Missed or doubled edge detection shows as outputs changing without a strobe, and the bound checker flags that within one cycle.

// File: rtl/dacfe_pkg.sv
// Shared constants and pin indices for the DAC command front end.
// Assumes: the four host pins are carried as one bus in the order below.
package dacfe_pkg;
    localparam int N_PINS = 4;
    typedef enum int {
        PIN_SCLK = 0,
        PIN_SDAT = 1,
        PIN_LD   = 2,
        PIN_UPD  = 3
    } pin_idx_e;
endpackage

// File: rtl/dacfe_sync.sv
// Multi-stage synchronizer with falling-edge detect, one chain per bit.
// Assumes: inputs are asynchronous and change slower than STAGES+1 clk cycles.
module dacfe_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] fall
);
    localparam int LAST = STAGES;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [LAST:0] chain;
        // Shift the pin through the chain; the extra stage holds the previous level.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[LAST-1:0], din[b]};
        end
        assign dout[b] = chain[LAST-1];
        assign fall[b] = chain[LAST] & ~chain[LAST-1];
    end
endmodule

// File: rtl/dacfe_shifter.sv
// Serial-in shift register for the command word, MSB arrives first.
// Assumes: en is a one-cycle pulse per serial bit.
module dacfe_shifter #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_o
);
    // Shift one bit in at the LSB on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  word_o <= '0;
        else if (en) word_o <= {word_o[WORD_W-2:0], bit_in};
    end
endmodule

// File: rtl/dacfe_bank.sv
// Held and output registers for all channels, two levels deep.
// Assumes: wr and xfer_all are one-cycle pulses; a same-cycle write is
// seen by the global transfer.
module dacfe_bank #(
    parameter int NCH = 8,
    parameter int CW  = 8,
    localparam int AW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     wr_addr,
    input  logic              wr_rng,
    input  logic [CW-1:0]     wr_code,
    input  logic              wr_now,
    input  logic              xfer_all,
    output logic [NCH*CW-1:0] code_o,
    output logic [NCH-1:0]    range_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CW-1:0] held_code, held_code_nx;
        logic          held_rng,  held_rng_nx;
        logic          sel;

        // Next held value, including a write landing this cycle.
        always_comb begin
            sel          = wr && (wr_addr == AW'(c));
            held_code_nx = sel ? wr_code : held_code;
            held_rng_nx  = sel ? wr_rng  : held_rng;
        end

        // Held register: written by the load strobe only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_code <= '0;
                held_rng  <= 1'b0;
            end else begin
                held_code <= held_code_nx;
                held_rng  <= held_rng_nx;
            end
        end

        // Output register: global transfer or immediate write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_o[c*CW +: CW] <= '0;
                range_o[c]         <= 1'b0;
            end else if (xfer_all || (sel && wr_now)) begin
                code_o[c*CW +: CW] <= held_code_nx;
                range_o[c]         <= held_rng_nx;
            end
        end
    end
endmodule

// File: rtl/octal_dac_frontend.sv
// Top level: synchronizes the four host pins, shifts in the command word,
// and drives the double-buffered channel registers.
// Assumes: clk runs at least 8x the serial clock.
module octal_dac_frontend #(
    parameter int NCH         = 8,
    parameter int CW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_ld,
    input  logic              upd_n,
    output logic [NCH*CW-1:0] code_o,
    output logic [NCH-1:0]    range_o
);
    import dacfe_pkg::*;
    localparam int AW     = $clog2(NCH);
    localparam int WORD_W = AW + 1 + CW;

    logic [N_PINS-1:0] pins, lvl, fall;
    logic [WORD_W-1:0] word;
    logic              ld_fall, up_fall, upd_lvl, shift_en;

    assign pins[PIN_SCLK] = ser_clk;
    assign pins[PIN_SDAT] = ser_dat;
    assign pins[PIN_LD]   = ser_ld;
    assign pins[PIN_UPD]  = upd_n;

    dacfe_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pins), .dout(lvl), .fall(fall)
    );

    // Edge qualifiers used by the shifter and the bank.
    always_comb begin
        shift_en = fall[PIN_SCLK] & lvl[PIN_LD];
        ld_fall  = fall[PIN_LD];
        up_fall  = fall[PIN_UPD];
        upd_lvl  = lvl[PIN_UPD];
    end

    dacfe_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(shift_en),
        .bit_in(lvl[PIN_SDAT]), .word_o(word)
    );

    dacfe_bank #(.NCH(NCH), .CW(CW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr(ld_fall),
        .wr_addr(word[WORD_W-1 -: AW]),
        .wr_rng(word[CW]),
        .wr_code(word[CW-1:0]),
        .wr_now(~upd_lvl),
        .xfer_all(up_fall),
        .code_o(code_o),
        .range_o(range_o)
    );
endmodule

// File: rtl/dacfe_checker.sv
// Assertion checker bound to the top: reset state, output stability and
// single-lane immediate writes.
module dacfe_checker #(
    parameter int NCH = 8,
    parameter int CW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH*CW-1:0] code_o,
    input logic [NCH-1:0]    range_o,
    input logic              ld_fall,
    input logic              up_fall,
    input logic              upd_lvl
);
    logic              after_rst = 1'b0;
    logic [NCH*CW-1:0] prev_code;
    logic [NCH-1:0]    chg;

    // Remember the previous cycle's reset and codes.
    always_ff @(posedge clk) begin
        after_rst <= !rst_n;
        prev_code <= code_o;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chg
        assign chg[c] = code_o[c*CW +: CW] != prev_code[c*CW +: CW];
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst |-> (code_o == '0 && range_o == '0)); // R1
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_fall && !up_fall) |=> $stable(code_o)); // R10
    AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_fall && !up_fall) |=> $stable(range_o)); // R10
    AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fall && upd_lvl && !up_fall) |=> ($stable(code_o) && $stable(range_o))); // R6
    AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fall && !up_fall) |=> ($countones(chg) <= 1)); // R5
endmodule

bind octal_dac_frontend dacfe_checker #(.NCH(NCH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .code_o(code_o), .range_o(range_o),
    .ld_fall(ld_fall), .up_fall(up_fall), .upd_lvl(upd_lvl)
);

// File: tb/sim_octal_dac_frontend.sv
module sim_octal_dac_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int HB = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b1, upd_n = 1'b0;
    logic [63:0] code_o;
    logic [7:0]  range_o;

    int n_checks = 0, n_errors = 0;
    logic [7:0] held_c [8], out_c [8];
    logic       held_r [8], out_r [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    octal_dac_frontend u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_ld(ser_ld), .upd_n(upd_n),
        .code_o(code_o), .range_o(range_o));

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            held_c[i] = 0; out_c[i] = 0; held_r[i] = 0; out_r[i] = 0;
        end
    endtask

    task automatic check_all(input string req);
        logic [63:0] ec;
        logic [7:0]  er;
        for (int i = 0; i < 8; i++) begin
            ec[i*8 +: 8] = out_c[i];
            er[i] = out_r[i];
        end
        n_checks++;
        if (code_o !== ec || range_o !== er) begin
            n_errors++;
            $display("FAIL %s: code %h range %b, expected code %h range %b",
                     req, code_o, range_o, ec, er);
        end
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            ser_clk = 1'b1; wait_clk(HB);
            ser_clk = 1'b0; wait_clk(HB);
        end
    endtask

    // Pulse the load strobe and update the model for a 12-bit word.
    task automatic pulse_ld(input logic [11:0] w);
        int a;
        a = int'(w[11:9]);
        held_c[a] = w[7:0];
        held_r[a] = w[8];
        if (!upd_n) begin out_c[a] = w[7:0]; out_r[a] = w[8]; end
        ser_ld = 1'b0; wait_clk(HB);
        ser_ld = 1'b1; wait_clk(HB);
    endtask

    task automatic send(input logic [2:0] a, input logic r, input logic [7:0] c);
        shift_bits({4'h0, a, r, c}, 12);
        pulse_ld({a, r, c});
    endtask

    task automatic pulse_upd();
        upd_n = 1'b1; wait_clk(HB);
        upd_n = 1'b0;
        for (int i = 0; i < 8; i++) begin out_c[i] = held_c[i]; out_r[i] = held_r[i]; end
        wait_clk(HB);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wait_clk(3);
        rst_n = 1'b1; model_reset(); wait_clk(2);
        check_all("R1 reset state");
    endtask

    task automatic t_immediate();
        upd_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            send(3'(i), i[0], 8'(8'h11 * (i + 1) ^ 8'h5A));
            check_all("R3 R4 R5 immediate write");
        end
    endtask

    task automatic t_deferred();
        upd_n = 1'b1; wait_clk(HB);
        send(3'd3, 1'b0, 8'hC3);
        check_all("R6 deferred hold");
        send(3'd6, 1'b1, 8'h0F);
        check_all("R6 deferred hold second");
        upd_n = 1'b0;
        for (int i = 0; i < 8; i++) begin out_c[i] = held_c[i]; out_r[i] = held_r[i]; end
        wait_clk(HB);
        check_all("R7 global transfer");
    endtask

    task automatic t_long_frame();
        upd_n = 1'b0;
        shift_bits({4'b1011, 3'd5, 1'b1, 8'hA6}, 16);
        pulse_ld({3'd5, 1'b1, 8'hA6});
        check_all("R8 last 12 bits used");
    endtask

    task automatic t_ignore_low();
        upd_n = 1'b1; wait_clk(HB);
        shift_bits({4'h0, 3'd2, 1'b0, 8'h3C}, 12);
        held_c[2] = 8'h3C; held_r[2] = 1'b0;
        ser_ld = 1'b0; wait_clk(HB);
        shift_bits(16'hFFFF, 12);
        ser_ld = 1'b1; wait_clk(HB);
        check_all("R6 held only");
        upd_n = 1'b0;
        for (int i = 0; i < 8; i++) begin out_c[i] = held_c[i]; out_r[i] = held_r[i]; end
        wait_clk(HB);
        pulse_ld({3'd2, 1'b0, 8'h3C});
        check_all("R2 clocks ignored while load low");
    endtask

    task automatic t_same_cycle();
        upd_n = 1'b1; wait_clk(HB);
        send(3'd1, 1'b1, 8'h77);
        shift_bits({4'h0, 3'd7, 1'b0, 8'hE1}, 12);
        held_c[7] = 8'hE1; held_r[7] = 1'b0;
        for (int i = 0; i < 8; i++) begin out_c[i] = held_c[i]; out_r[i] = held_r[i]; end
        ser_ld = 1'b0; upd_n = 1'b0; wait_clk(HB);
        ser_ld = 1'b1; wait_clk(HB);
        check_all("R9 same-cycle load and update");
    endtask

    task automatic t_latency();
        upd_n = 1'b0;
        shift_bits({4'h0, 3'd0, 1'b1, 8'h99}, 12);
        @(posedge clk); #1;
        ser_ld = 1'b0;
        wait_clk(2);
        check_all("R10 no change before third edge");
        out_c[0] = 8'h99; out_r[0] = 1'b1; held_c[0] = 8'h99; held_r[0] = 1'b1;
        wait_clk(1);
        check_all("R10 change at third edge");
        wait_clk(HB);
        ser_ld = 1'b1; wait_clk(HB);
    endtask

    task automatic t_reset_mid();
        rst_n = 1'b0; wait_clk(2);
        model_reset();
        check_all("R1 mid-run reset");
        rst_n = 1'b1; wait_clk(2);
        pulse_upd();
        check_all("R1 held registers cleared");
    endtask

    initial begin
        model_reset();
        t_reset();
        t_immediate();
        t_deferred();
        t_long_frame();
        t_ignore_low();
        t_same_cycle();
        t_latency();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule